// File: doc/BRIEF.md
# Decimal and Unpacked-Digit Adjust Unit

This unit performs the correction step that follows byte arithmetic on decimal data. It takes the low and high accumulator bytes (called AL and AH here), the incoming carry and half-carry flags, and a 3-bit operation code. It returns the corrected bytes together with carry, half-carry, zero, sign and parity flags. Six corrections are supported. Four work on unpacked digits, one per byte: after an add, after a subtract, after a multiply (split a binary byte into two digits), and before a divide (fold two digits into one binary byte). Two work on packed digits, two per byte: after an add and after a subtract.

A request is a single-cycle `start` pulse with the operands. Most operations answer on the clock edge that accepts the request. The split-into-digits operation divides by ten with a restoring bit-serial divider and answers eight cycles later. While that divide runs, `busy` is high and further requests are ignored. Results stay on the outputs until the next completion.

Top module: `bcd_adjust_unit`

## Requirements
- R1: With op=0 (unpacked after add), if AL[3:0] > 9 or the half-carry input is 1, then AL becomes ((AL[3:0]+6) mod 16), AH becomes AH+1 mod 256, and both carry and half-carry become 1. Otherwise AL becomes AL[3:0], AH is unchanged, and carry and half-carry become 0.
- R2: With op=1 (unpacked after subtract), the same condition applies. When it holds, AL becomes ((AL[3:0]-6) mod 16), AH becomes AH-1 mod 256, and carry and half-carry become 1. Otherwise AL becomes AL[3:0], AH is unchanged, and both flags become 0.
- R3: With op=2 (split into digits), AH becomes AL/10 and AL becomes AL mod 10. Carry and half-carry pass through unchanged. `done` rises 8 clock edges after the edge that accepts `start`, and `busy` is high in between.
- R4: With op=3 (fold digits), AL becomes (AH*10 + AL) mod 256 and AH becomes 0. Carry and half-carry pass through.
- R5: With op=4 (packed after add), let lo = (AL[3:0] > 9 or half-carry in) and hi = (AL > 0x99 or carry in). AL becomes AL + 6*lo + 0x60*hi mod 256, half-carry out is lo, carry out is hi, and AH is unchanged.
- R6: With op=5 (packed after subtract), lo and hi are formed as in R5. AL becomes AL - 6*lo - 0x60*hi mod 256, half-carry out is lo, carry out is hi, and AH is unchanged.
- R7: With op=6 or op=7, AL, AH, carry and half-carry all pass through unchanged.
- R8: For every operation, zero is 1 exactly when the final AL is 0, sign equals the final AL[7], and parity is 1 when the final AL has an even number of 1 bits.
- R9: Every operation other than op=2 raises `done` on the edge that accepts `start`. `done` lasts one cycle per operation, and `busy` and `done` are never high together.
- R10: A `start` while `busy` is high is ignored. The running divide completes with its original operands, and only one `done` pulse appears.
- R11: After a synchronous active-low reset, `done` and `busy` are 0, AL, AH, carry and half-carry are 0, zero is 1, sign is 0 and parity is 1.
- R12: Between completions the outputs AL and AH hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse, accepted when not busy |
| op | input | 3 | Operation select (0..7, see R1-R7 codes) |
| al_in | input | 8 | Low accumulator byte operand |
| ah_in | input | 8 | High accumulator byte operand |
| cf_in | input | 1 | Incoming carry flag |
| af_in | input | 1 | Incoming half-carry flag |
| busy | output | 1 | Divide by ten in progress |
| done | output | 1 | One-cycle completion pulse |
| al_out | output | 8 | Corrected low byte |
| ah_out | output | 8 | Corrected high byte |
| cf_out | output | 1 | Carry flag out |
| af_out | output | 1 | Half-carry flag out |
| zf_out | output | 1 | Zero flag of final low byte |
| sf_out | output | 1 | Sign flag of final low byte |
| pf_out | output | 1 | Even-parity flag of final low byte |

## Verification
The bench builds the unit with its default parameters: an 8-bit byte and radix ten. This makes the divider run exactly eight steps and keeps every operand byte within reach of random stimulus. Random operands with random flag inputs cover the nibble and high-part thresholds around 9 and 0x99, wraparound of AH, and quotients up to 25. Directed cases pin the worked examples, zero results, and a second request issued while the divide is running.

// File: rtl/bcd_adj_pkg.sv
// Package: shared operation codes and result record for the decimal adjust unit.
// Assumes an 8-bit byte split into two 4-bit digits.
package bcd_adj_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        OP_ASC_ADD = 3'd0,
        OP_ASC_SUB = 3'd1,
        OP_ASC_MUL = 3'd2,
        OP_ASC_DIV = 3'd3,
        OP_DEC_ADD = 3'd4,
        OP_DEC_SUB = 3'd5,
        OP_RSV_6   = 3'd6,
        OP_RSV_7   = 3'd7
    } adj_op_e;

    typedef struct packed {
        logic [BYTE_W-1:0] al;
        logic [BYTE_W-1:0] ah;
        logic              cf;
        logic              af;
    } adj_res_t;

endpackage

// File: rtl/bcd_nibble_fix.sv
// Module: single-cycle nibble corrections for the unpacked add/subtract
// and packed add/subtract operations. Any other code passes its operands
// through. Assumes an 8-bit byte; the digit thresholds are 9 and 0x99.
module bcd_nibble_fix
    import bcd_adj_pkg::*;
(
    input  adj_op_e    op,
    input  logic [7:0] al_in,
    input  logic [7:0] ah_in,
    input  logic       cf_in,
    input  logic       af_in,
    output adj_res_t   res
);

    logic       lo_fix;
    logic       hi_fix;
    logic [3:0] lo_up;
    logic [3:0] lo_dn;

    // Purpose: form the correction conditions and corrected low digits.
    always_comb begin
        lo_fix = (al_in[3:0] > 4'd9) || af_in;
        hi_fix = (al_in > 8'h99) || cf_in;
        lo_up  = al_in[3:0] + 4'd6;
        lo_dn  = al_in[3:0] - 4'd6;
    end

    // Purpose: select the correction for the requested operation.
    always_comb begin
        res = '{al: al_in, ah: ah_in, cf: cf_in, af: af_in};
        case (op)
            OP_ASC_ADD, OP_ASC_SUB: begin
                if (lo_fix) begin
                    res.al = {4'h0, (op == OP_ASC_ADD) ? lo_up : lo_dn};
                    res.ah = (op == OP_ASC_ADD) ? ah_in + 8'd1 : ah_in - 8'd1;
                    res.cf = 1'b1;
                    res.af = 1'b1;
                end else begin
                    res.al = {4'h0, al_in[3:0]};
                    res.cf = 1'b0;
                    res.af = 1'b0;
                end
            end
            OP_DEC_ADD: begin
                res.al = al_in + (lo_fix ? 8'h06 : 8'h00) + (hi_fix ? 8'h60 : 8'h00);
                res.cf = hi_fix;
                res.af = lo_fix;
            end
            OP_DEC_SUB: begin
                res.al = al_in - (lo_fix ? 8'h06 : 8'h00) - (hi_fix ? 8'h60 : 8'h00);
                res.cf = hi_fix;
                res.af = lo_fix;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/bcd_fold_digits.sv
// Module: combinational fold of two digits into one binary value:
// hi*RADIX + lo, truncated to DW bits. Assumes the inputs are already digits;
// it does not check that.
module bcd_fold_digits #(
    parameter int DW    = 8,
    parameter int RADIX = 10
) (
    input  logic [DW-1:0] hi,
    input  logic [DW-1:0] lo,
    output logic [DW-1:0] folded
);

    localparam logic [DW-1:0] RADIX_V = DW'(RADIX);
    localparam int            PW      = 2 * DW;

    logic [PW-1:0] prod;

    // Purpose: scale the high digit and add the low digit.
    always_comb begin
        prod   = {{DW{1'b0}}, hi} * {{DW{1'b0}}, RADIX_V};
        folded = prod[DW-1:0] + lo;
    end

endmodule

// File: rtl/bcd_div_iter.sv
// Module: restoring bit-serial divider by a constant. It produces one
// quotient bit per step, MSB first. load captures the dividend and clears
// the remainder. The *_nx outputs show the values after the current step,
// so the caller can capture them on the final step edge.
module bcd_div_iter #(
    parameter int DW      = 8,
    parameter int DIVISOR = 10
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            load,
    input  logic                            step,
    input  logic [DW-1:0]                   dividend,
    output logic [DW-1:0]                   quot_nx,
    output logic [$clog2(DIVISOR+1)-1:0]    rem_nx
);

    localparam int RW = $clog2(DIVISOR + 1) + 1;

    logic [DW-1:0] dvd_q;
    logic [RW-1:0] rem_q;
    logic [RW-1:0] trial;
    logic          fits;
    logic [RW-1:0] rem_n;

    // Purpose: one trial subtraction of the divisor.
    always_comb begin
        trial   = {rem_q[RW-2:0], dvd_q[DW-1]};
        fits    = trial >= RW'(DIVISOR);
        rem_n   = fits ? trial - RW'(DIVISOR) : trial;
        quot_nx = {dvd_q[DW-2:0], fits};
        rem_nx  = rem_n[RW-2:0];
    end

    // Purpose: hold the shifting dividend/quotient and the partial remainder.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dvd_q <= '0;
            rem_q <= '0;
        end else if (load) begin
            dvd_q <= dividend;
            rem_q <= '0;
        end else if (step) begin
            dvd_q <= quot_nx;
            rem_q <= rem_n;
        end
    end

endmodule

// File: rtl/bcd_adjust_unit.sv
// Module: top of the decimal adjust unit. It accepts a request when idle.
// The split-into-digits operation runs an iterative divide over BYTE_W
// cycles; every other operation completes on the accepting edge.
// Assumes an 8-bit byte for the nibble corrections.
module bcd_adjust_unit
    import bcd_adj_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int RADIX  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op,
    input  logic [BYTE_W-1:0] al_in,
    input  logic [BYTE_W-1:0] ah_in,
    input  logic              cf_in,
    input  logic              af_in,
    output logic              busy,
    output logic              done,
    output logic [BYTE_W-1:0] al_out,
    output logic [BYTE_W-1:0] ah_out,
    output logic              cf_out,
    output logic              af_out,
    output logic              zf_out,
    output logic              sf_out,
    output logic              pf_out
);

    localparam int CW  = $clog2(BYTE_W);
    localparam int REM = $clog2(RADIX + 1);

    typedef enum logic {ST_IDLE, ST_DIVIDE} state_e;

    state_e            state_q;
    logic [CW-1:0]     step_cnt_q;
    logic              cf_hold_q;
    logic              af_hold_q;
    logic [BYTE_W-1:0] al_q;
    logic [BYTE_W-1:0] ah_q;
    logic              cf_q;
    logic              af_q;
    logic              done_q;

    adj_op_e           op_e;
    logic              accept;
    logic              is_split;
    adj_res_t          fix_res;
    logic [BYTE_W-1:0] folded;
    logic [BYTE_W-1:0] quot_nx;
    logic [REM-1:0]    rem_nx;

    // Purpose: decode the request.
    always_comb begin
        op_e     = adj_op_e'(op);
        accept   = start && (state_q == ST_IDLE);
        is_split = (op_e == OP_ASC_MUL);
    end

    bcd_nibble_fix u_fix (
        .op    (op_e),
        .al_in (al_in),
        .ah_in (ah_in),
        .cf_in (cf_in),
        .af_in (af_in),
        .res   (fix_res)
    );

    bcd_fold_digits #(.DW(BYTE_W), .RADIX(RADIX)) u_fold (
        .hi     (ah_in),
        .lo     (al_in),
        .folded (folded)
    );

    bcd_div_iter #(.DW(BYTE_W), .DIVISOR(RADIX)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept && is_split),
        .step     (state_q == ST_DIVIDE),
        .dividend (al_in),
        .quot_nx  (quot_nx),
        .rem_nx   (rem_nx)
    );

    // Purpose: sequence requests and register the results and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            step_cnt_q <= '0;
            cf_hold_q  <= 1'b0;
            af_hold_q  <= 1'b0;
            al_q       <= '0;
            ah_q       <= '0;
            cf_q       <= 1'b0;
            af_q       <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (is_split) begin
                            state_q    <= ST_DIVIDE;
                            step_cnt_q <= '0;
                            cf_hold_q  <= cf_in;
                            af_hold_q  <= af_in;
                        end else begin
                            done_q <= 1'b1;
                            if (op_e == OP_ASC_DIV) begin
                                al_q <= folded;
                                ah_q <= '0;
                                cf_q <= cf_in;
                                af_q <= af_in;
                            end else begin
                                al_q <= fix_res.al;
                                ah_q <= fix_res.ah;
                                cf_q <= fix_res.cf;
                                af_q <= fix_res.af;
                            end
                        end
                    end
                end
                ST_DIVIDE: begin
                    step_cnt_q <= step_cnt_q + 1'b1;
                    if (step_cnt_q == CW'(BYTE_W - 1)) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                        al_q    <= BYTE_W'(rem_nx);
                        ah_q    <= quot_nx;
                        cf_q    <= cf_hold_q;
                        af_q    <= af_hold_q;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Purpose: drive the outputs and derive the result flags from the final low byte.
    always_comb begin
        busy   = (state_q == ST_DIVIDE);
        done   = done_q;
        al_out = al_q;
        ah_out = ah_q;
        cf_out = cf_q;
        af_out = af_q;
        zf_out = (al_q == '0);
        sf_out = al_q[BYTE_W-1];
        pf_out = ~^al_q;
    end

endmodule

// File: rtl/bcd_adjust_chk.sv
// Module: property checker for bcd_adjust_unit, attached by bind. It
// remembers the code of the last accepted request from the ports, and it
// counts busy cycles itself so that no deep $past is needed.
module bcd_adjust_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [2:0]        op,
    input logic              busy,
    input logic              done,
    input logic [BYTE_W-1:0] al_out,
    input logic [BYTE_W-1:0] ah_out,
    input logic              cf_out,
    input logic              af_out
);

    logic [2:0]  op_seen;
    logic [31:0] busy_run;

    // Purpose: track the accepted operation code and the length of the busy run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_seen  <= 3'd7;
            busy_run <= '0;
        end else begin
            if (start && !busy) op_seen <= op;
            busy_run <= busy ? busy_run + 32'd1 : 32'd0;
        end
    end

    a_r9_busy_excl_done: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

    a_r3_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_run < BYTE_W));

    a_r3_split_digits: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_seen == 3'd2) |-> (al_out < 10 && ah_out < 26));

    a_r1_unpacked_hi_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (op_seen == 3'd0 || op_seen == 3'd1)) |-> (al_out[BYTE_W-1:4] == '0 && cf_out == af_out));

    a_r4_fold_ah_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_seen == 3'd3) |-> (ah_out == '0));

    a_r12_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(al_out) && $stable(ah_out)));

endmodule

bind bcd_adjust_unit bcd_adjust_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .op     (op),
    .busy   (busy),
    .done   (done),
    .al_out (al_out),
    .ah_out (ah_out),
    .cf_out (cf_out),
    .af_out (af_out)
);

// File: tb/sim_bcd_adjust_unit.sv
module sim_bcd_adjust_unit;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [7:0] al;
        logic [7:0] ah;
        logic       cf;
        logic       af;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] op = 3'd0;
    logic [7:0] al_in = 8'd0;
    logic [7:0] ah_in = 8'd0;
    logic       cf_in = 1'b0;
    logic       af_in = 1'b0;
    logic       busy, done, cf_out, af_out, zf_out, sf_out, pf_out;
    logic [7:0] al_out, ah_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bcd_adjust_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .al_in(al_in), .ah_in(ah_in), .cf_in(cf_in), .af_in(af_in),
        .busy(busy), .done(done), .al_out(al_out), .ah_out(ah_out),
        .cf_out(cf_out), .af_out(af_out), .zf_out(zf_out),
        .sf_out(sf_out), .pf_out(pf_out)
    );

    function automatic exp_t model(input int o, input int a, input int h, input int c, input int f);
        exp_t e;
        int lo_c, hi_c, r;
        e = '{al: 8'(a), ah: 8'(h), cf: c[0], af: f[0]};
        lo_c = ((a % 16) > 9 || f != 0) ? 1 : 0;
        hi_c = (a > 153 || c != 0) ? 1 : 0;
        case (o)
            0, 1: begin
                if (lo_c != 0) begin
                    r = (o == 0) ? (a + 6) : (a + 250);
                    e.al = 8'(r % 16);
                    e.ah = 8'((o == 0) ? (h + 1) % 256 : (h + 255) % 256);
                    e.cf = 1'b1; e.af = 1'b1;
                end else begin
                    e.al = 8'(a % 16);
                    e.cf = 1'b0; e.af = 1'b0;
                end
            end
            2: begin e.ah = 8'(a / 10); e.al = 8'(a % 10); end
            3: begin e.al = 8'((h * 10 + a) % 256); e.ah = 8'd0; end
            4: begin e.al = 8'((a + 6 * lo_c + 96 * hi_c) % 256); e.cf = hi_c[0]; e.af = lo_c[0]; end
            5: begin e.al = 8'((a + 512 - 6 * lo_c - 96 * hi_c) % 256); e.cf = hi_c[0]; e.af = lo_c[0]; end
            default: ;
        endcase
        return e;
    endfunction

    function automatic string tag_of(input int o);
        case (o)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            5: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic run_op(input int o, input int a, input int h, input int c, input int f);
        exp_t e, g;
        int lat;
        int zeros;
        @(negedge clk);
        op = 3'(o); al_in = 8'(a); ah_in = 8'(h); cf_in = c[0]; af_in = f[0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        g = '{al: al_out, ah: ah_out, cf: cf_out, af: af_out};
        e = model(o, a, h, c, f);
        check(g == e, tag_of(o), $sformatf("op%0d al=%h ah=%h cf=%0d af=%0d result", o, a, h, c, f), 32'(g), 32'(e));
        zeros = (e.al == 8'd0) ? 1 : 0;
        // R8: flags from the final low byte
        check({zf_out, sf_out, pf_out} == {zeros[0], e.al[7], ~^e.al}, "R8", "zf/sf/pf",
              32'({zf_out, sf_out, pf_out}), 32'({zeros[0], e.al[7], ~^e.al}));
        // R9 (single-cycle ops) / R3 (divide) latency
        check(lat == ((o == 2) ? 9 : 1), (o == 2) ? "R3" : "R9", "done latency", 32'(lat), 32'((o == 2) ? 9 : 1));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        exp_t e;
        logic [7:0] held_al;
        void'($urandom(32'h5EED_0042));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        check({done, busy, al_out, ah_out, cf_out, af_out, zf_out, sf_out, pf_out} == {2'b00, 16'h0000, 2'b00, 3'b101},
              "R11", "reset outputs", 32'({done, busy, al_out, ah_out, cf_out, af_out, zf_out, sf_out, pf_out}),
              32'({2'b00, 16'h0000, 2'b00, 3'b101}));

        // Directed corner cases
        run_op(0, 8'h6A, 8'h00, 0, 0);   // R1 nibble above 9
        run_op(0, 8'h67, 8'h12, 1, 0);   // R1 no correction
        run_op(0, 8'h03, 8'hFF, 0, 1);   // R1 half-carry forces, AH wraps
        run_op(1, 8'h6A, 8'h05, 0, 0);   // R2
        run_op(1, 8'h05, 8'h00, 0, 1);   // R2 AH wraps down
        run_op(2, 8'h24, 8'h77, 1, 0);   // R3 36 -> 3,6
        run_op(2, 8'hFF, 8'h00, 0, 1);   // R3 255 -> 25,5
        run_op(2, 8'h00, 8'h11, 0, 0);   // R3 zero result
        run_op(3, 8'h05, 8'h01, 0, 0);   // R4 -> 0x0F
        run_op(3, 8'h09, 8'h09, 1, 1);   // R4 -> 99
        run_op(4, 8'h7C, 8'h00, 0, 0);   // R5 -> 0x82
        run_op(4, 8'h9A, 8'h00, 0, 0);   // R5 both corrections
        run_op(4, 8'h00, 8'h00, 1, 0);   // R5 carry-in high fix
        run_op(5, 8'h0A, 8'h00, 0, 0);   // R6 -> 0x04
        run_op(5, 8'h00, 8'h00, 1, 1);   // R6 both corrections
        run_op(6, 8'hC3, 8'h5A, 1, 0);   // R7
        run_op(7, 8'h00, 8'hA5, 0, 1);   // R7

        // R9: done is a single-cycle pulse
        @(negedge clk);
        check(done == 1'b0, "R9", "done one cycle", 32'(done), 32'd0);

        // R10: start while busy is ignored
        @(negedge clk);
        op = 3'd2; al_in = 8'd99; ah_in = 8'h00; cf_in = 1'b0; af_in = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        op = 3'd3; al_in = 8'h01; ah_in = 8'h02; cf_in = 1'b1; af_in = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        e = model(2, 99, 0, 0, 1);
        check(done == 1'b1, "R10", "done of divide", 32'(done), 32'd1);
        check({al_out, ah_out, cf_out, af_out} == e, "R10", "divide result kept",
              32'({al_out, ah_out, cf_out, af_out}), 32'(e));
        held_al = al_out;
        @(negedge clk);
        check(done == 1'b0, "R10", "no second done", 32'(done), 32'd0);
        // R12: outputs hold between completions
        repeat (3) @(negedge clk);
        check(al_out == held_al, "R12", "al hold", 32'(al_out), 32'(held_al));

        // Constrained random mix
        for (int i = 0; i < 300; i++) begin
            int o;
            int a;
            o = int'($urandom_range(7, 0));
            a = (i % 4 == 0) ? int'($urandom_range(12, 6)) + 16 * int'($urandom_range(10, 8))
                             : int'($urandom_range(255, 0));
            run_op(o, a, int'($urandom_range(255, 0)), int'($urandom_range(1, 0)), int'($urandom_range(1, 0)));
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule